// File: doc/BRIEF.md
# Sub-word Load/Store Alignment Unit

This unit sits between a processor core and a data memory organised as 32-bit words, and it handles accesses that are narrower than a word. Each request carries a base register value, a signed 16-bit displacement, an access size, a store/load flag, a sign-handling flag and store data. The unit adds the displacement to the base to form a byte address and checks that the address is naturally aligned for the size. One clock later it presents the memory with a word-aligned address. For a store it also presents lane-replicated write data and a per-byte write-enable mask.

For loads, the memory returns the full addressed word in the same cycle that the unit drives the address. The unit picks out the addressed byte or halfword from that word, then sign-extends or zero-extends it to 32 bits. It registers the result one cycle after the memory address. A request that breaks alignment raises an error flag and writes nothing. If that request is a load, it returns zero. Byte lanes are little-endian.

Top module: `lsu_align`

## Requirements
- R1: The effective byte address is `req_base` plus the sign-extended `req_offset`. One cycle after a valid request, `mem_addr` shows that address with bits [1:0] forced to zero. After an idle cycle, `mem_addr` is zero.
- R2: For a byte store (`req_size` = 2'b00), `mem_wdata` holds bits [7:0] of the store data repeated in all four lanes. `mem_be` is one-hot, with bit k set for address bits [1:0] = k. Lane k is data bits [8k+7:8k].
- R3: For a halfword store (`req_size` = 2'b01), `mem_wdata` holds bits [15:0] of the store data repeated in both halves. `mem_be` is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1.
- R4: For a word store (`req_size` = 2'b10), `mem_be` is 4'b1111 and `mem_wdata` equals the store data.
- R5: A request is misaligned in three cases: a halfword at an odd address, a word whose address bits [1:0] are not 00, or any request with `req_size` = 2'b11. For a misaligned request, `misalign_err` is 1 one cycle later, while `mem_we`, `mem_re`, `mem_be` and `mem_wdata` are all zero. The memory contents do not change.
- R6: For a byte load, `ld_data` is the addressed byte. It is sign-extended when `req_unsigned` = 0 and zero-extended when `req_unsigned` = 1.
- R7: For a halfword load, `ld_data` is the addressed halfword. It is sign-extended when `req_unsigned` = 0 and zero-extended when `req_unsigned` = 1.
- R8: Every load request gives `ld_valid` = 1 two cycles after the request. A word load returns the memory word unchanged, and a misaligned load returns zero.
- R9: While `rst` is high, and in the first cycle after it, every output is zero.
- R10: For an aligned load, `mem_re` is 1 and `mem_we` is 0. For an aligned store, the reverse holds. A cycle with no request leaves every output zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | Zero-extend load data instead of sign-extending |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_be | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Word read from memory, valid while mem_re is high |
| misalign_err | output | 1 | Alignment violation for the request of the previous cycle |
| ld_valid | output | 1 | Load result is present |
| ld_data | output | 32 | Extended load result |

## Verification
The assertions check, on every cycle, the invariants that do not depend on data values. The memory address always has its two low bits clear. Write and read strobes never occur together. An error always comes with empty enables. A store enables exactly one, two or four lanes, and the high-half lanes appear only together. Every load produces a result one cycle after it reaches memory, and a misaligned load produces zero. The bench's scenarios are needed to show the actual values. Those are: the effective-address sum with negative displacements, the lane each address selects, the replicated write data, the sign handling of bytes and halfwords with the top bit set, and the fact that rejected stores leave memory untouched.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LB     = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic              aligned
);
  localparam int EXT_W = ADDR_W - OFF_W;

  always_comb begin
    ea = base + {{EXT_W{offset[OFF_W-1]}}, offset};
    unique case (size)
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = ~ea[0];
      SZ_WORD: aligned = (ea[LB-1:0] == '0);
      default: aligned = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LB     = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [LB-1:0]     lane,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          wdata[i*8 +: 8] = src[7:0];
          be[i]           = (lane == LB'(i));
        end
        SZ_HALF: begin
          wdata[i*8 +: 8] = src[(i%2)*8 +: 8];
          be[i]           = (lane[LB-1:1] == (LB-1)'(i/2));
        end
        default: begin
          wdata[i*8 +: 8] = src[i*8 +: 8];
          be[i]           = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LB     = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [LB-1:0]     lane,
  input  logic              zext,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    sel_b = word[lane*8 +: 8];
    sel_h = word[lane[LB-1:1]*16 +: 16];
    unique case (size)
      SZ_BYTE: result = {{(DATA_W-8){~zext & sel_b[7]}}, sel_b};
      SZ_HALF: result = {{(DATA_W-16){~zext & sel_h[15]}}, sel_h};
      default: result = word;
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LB    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              misalign_err,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  acc_size_e         size_in;
  logic [ADDR_W-1:0] ea;
  logic              aligned;
  logic [DATA_W-1:0] st_wdata;
  logic [LANES-1:0]  st_be;
  logic              st_ok;
  logic              ld_ok;

  // stage-1 context kept for the load return
  logic              ld1_pend;
  logic [LB-1:0]     ld1_lane;
  acc_size_e         ld1_size;
  logic              ld1_zext;
  logic [DATA_W-1:0] ld_ext;

  assign size_in = acc_size_e'(req_size);
  assign st_ok   = req_valid & req_store & aligned;
  assign ld_ok   = req_valid & ~req_store & aligned;

  lsu_ea_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LB(LB)) u_ea (
    .base(req_base), .offset(req_offset), .size(size_in),
    .ea(ea), .aligned(aligned)
  );

  lsu_store_steer #(.DATA_W(DATA_W), .LANES(LANES), .LB(LB)) u_steer (
    .size(size_in), .lane(ea[LB-1:0]), .src(req_wdata),
    .wdata(st_wdata), .be(st_be)
  );

  lsu_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .LB(LB)) u_ext (
    .size(ld1_size), .lane(ld1_lane), .zext(ld1_zext),
    .word(mem_rdata), .result(ld_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr     <= '0;
      mem_we       <= 1'b0;
      mem_re       <= 1'b0;
      mem_be       <= '0;
      mem_wdata    <= '0;
      misalign_err <= 1'b0;
      ld1_pend     <= 1'b0;
      ld1_lane     <= '0;
      ld1_size     <= SZ_BYTE;
      ld1_zext     <= 1'b0;
      ld_valid     <= 1'b0;
      ld_data      <= '0;
    end else begin
      mem_addr     <= req_valid ? {ea[ADDR_W-1:LB], LB'(0)} : '0;
      mem_we       <= st_ok;
      mem_re       <= ld_ok;
      mem_be       <= st_ok ? st_be : '0;
      mem_wdata    <= st_ok ? st_wdata : '0;
      misalign_err <= req_valid & ~aligned;
      ld1_pend     <= req_valid & ~req_store;
      ld1_lane     <= ea[LB-1:0];
      ld1_size     <= size_in;
      ld1_zext     <= req_unsigned;
      ld_valid     <= ld1_pend;
      ld_data      <= (ld1_pend & ~misalign_err) ? ld_ext : '0;
    end
  end

  // R1: memory address is always word aligned
  a_r1_addr_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_addr[LB-1:0] == '0);

  // R5: an alignment error never comes with enables or strobes
  a_r5_err_quiet: assert property (@(posedge clk) disable iff (rst)
    misalign_err |-> (!mem_we && !mem_re && mem_be == '0 && mem_wdata == '0));

  // R10: read and write strobes are exclusive
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  // R2: a store enables one, two or all lanes, never other counts
  a_r2_be_count: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                || $countones(mem_be) == LANES));

  // R3: when exactly two lanes are enabled they form one aligned half
  a_r3_half_pair: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $countones(mem_be) == 2) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

  // R8: every aligned read yields a load result next cycle
  a_r8_read_returns: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> ld_valid);

  // R8: a misaligned load returns zero
  a_r8_misload_zero: assert property (@(posedge clk) disable iff (rst)
    (misalign_err && ld1_pend) |=> (ld_valid && ld_data == '0));
endmodule

// File: tb/lsu_align_tb.sv
module lsu_align_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_store, req_unsigned;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_wdata;
  logic [15:0] req_offset;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data;
  logic        mem_we, mem_re, misalign_err, ld_valid;
  logic [3:0]  mem_be;

  int checks = 0;
  int errors = 0;

  logic [31:0] bmem [16];
  assign mem_rdata = bmem[mem_addr[5:2]];

  always #4 clk = ~clk;

  lsu_align u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .misalign_err(misalign_err), .ld_valid(ld_valid),
    .ld_data(ld_data)
  );

  // reference model state
  logic [31:0] e1_addr, e1_wdata;
  logic [3:0]  e1_be;
  logic        e1_we, e1_re, e1_err, e1_ld, e1_uns;
  logic [1:0]  e1_size, e1_lane;
  string       e1_tag;
  logic        e2_v;
  logic [31:0] e2_d;
  string       e2_tag;

  function automatic logic [31:0] ref_load(logic [31:0] w, logic [1:0] sz,
                                           logic [1:0] ln, logic uns);
    int v;
    if (sz == 2'd0) begin
      v = int'((w >> (ln * 8)) & 32'hFF);
      if (!uns && v >= 128) v = v - 256;
    end else if (sz == 2'd1) begin
      v = int'((w >> ((ln / 2) * 16)) & 32'hFFFF);
      if (!uns && v >= 32768) v = v - 65536;
    end else v = int'(w);
    return 32'(v);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      e1_addr = 0; e1_wdata = 0; e1_be = 0; e1_we = 0; e1_re = 0; e1_err = 0;
      e1_ld = 0; e1_uns = 0; e1_size = 0; e1_lane = 0; e1_tag = "R10";
      e2_v = 0; e2_d = 0; e2_tag = "R8";
    end else begin
      logic [31:0] ea;
      logic ok;
      e2_v = e1_ld;
      e2_d = (e1_ld && !e1_err) ? ref_load(bmem[e1_addr[5:2]], e1_size, e1_lane, e1_uns) : 0;
      e2_tag = e1_err ? "R8" : (e1_size == 0 ? "R6" : (e1_size == 1 ? "R7" : "R8"));
      if (mem_we)
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) bmem[mem_addr[5:2]][k*8 +: 8] = mem_wdata[k*8 +: 8];
      ea = req_base + {{16{req_offset[15]}}, req_offset};
      case (req_size)
        2'd0: ok = 1;
        2'd1: ok = (ea % 2) == 0;
        2'd2: ok = (ea % 4) == 0;
        default: ok = 0;
      endcase
      e1_addr = req_valid ? (ea / 4) * 4 : 0;
      e1_err  = req_valid && !ok;
      e1_we   = req_valid && req_store && ok;
      e1_re   = req_valid && !req_store && ok;
      e1_ld   = req_valid && !req_store;
      e1_size = req_size; e1_lane = ea[1:0]; e1_uns = req_unsigned;
      e1_be = 0; e1_wdata = 0;
      if (e1_we) begin
        if (req_size == 0) begin
          e1_be = 4'(1 << ea[1:0]); e1_wdata = {4{req_wdata[7:0]}};
        end else if (req_size == 1) begin
          e1_be = (ea % 4 >= 2) ? 4'hC : 4'h3; e1_wdata = {2{req_wdata[15:0]}};
        end else begin
          e1_be = 4'hF; e1_wdata = req_wdata;
        end
      end
      if (!req_valid) e1_tag = "R10";
      else if (!ok) e1_tag = "R5";
      else if (!req_store) e1_tag = "R10";
      else e1_tag = req_size == 0 ? "R2" : (req_size == 1 ? "R3" : "R4");
    end
  end

  logic running = 1'b0;
  always @(negedge clk) begin
    if (running) begin
      chk("R1", "mem_addr", mem_addr, e1_addr);
      chk(e1_tag, "mem_be", 32'(mem_be), 32'(e1_be));
      chk(e1_tag, "mem_wdata", mem_wdata, e1_wdata);
      chk(e1_tag, "mem_we", 32'(mem_we), 32'(e1_we));
      chk("R10", "mem_re", 32'(mem_re), 32'(e1_re));
      chk("R5", "misalign_err", 32'(misalign_err), 32'(e1_err));
      chk("R8", "ld_valid", 32'(ld_valid), 32'(e2_v));
      chk(e2_tag, "ld_data", ld_data, e2_d);
    end
  end

  task automatic req(logic st, logic [1:0] sz, logic un, logic [31:0] b,
                     logic [15:0] o, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_store = st; req_size = sz; req_unsigned = un;
    req_base = b; req_offset = o; req_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_store = 0; req_size = 0; req_unsigned = 0;
    req_base = 0; req_offset = 0; req_wdata = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = 32'h0;
    rst = 1;
    req_valid = 0; req_store = 0; req_size = 0; req_unsigned = 0;
    req_base = 0; req_offset = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "mem_addr", mem_addr, 0);
    chk("R9", "mem_be", 32'(mem_be), 0);
    chk("R9", "strobes", 32'({mem_we, mem_re, misalign_err, ld_valid}), 0);
    chk("R9", "ld_data", ld_data, 0);
    @(posedge clk); rst = 0;
    running = 1;
    idle(); idle();
    // R4 word store, R2 byte stores to every lane, R3 halfword stores
    req(1, 2'd2, 0, 32'h100, 16'h0000, 32'h80FF7F01);
    req(1, 2'd0, 0, 32'h104, 16'h0000, 32'h123456A5);
    req(1, 2'd0, 0, 32'h104, 16'h0001, 32'hDEADBE80);
    req(1, 2'd0, 0, 32'h106, 16'h0000, 32'h0000007E);
    req(1, 2'd0, 0, 32'h108, 16'hFFFF, 32'h000000C3);
    req(1, 2'd1, 0, 32'h108, 16'h0000, 32'hABCD8001);
    req(1, 2'd1, 0, 32'h10C, 16'hFFFE, 32'h00007FFF);
    idle();
    // R6 byte loads, signed and unsigned, every lane
    for (int l = 0; l < 4; l++) begin
      req(0, 2'd0, 0, 32'h100, 16'(l), 0);
      req(0, 2'd0, 1, 32'h100, 16'(l), 0);
    end
    req(0, 2'd0, 0, 32'h105, 16'h0000, 0);
    // R7 halfword loads
    req(0, 2'd1, 0, 32'h100, 16'h0000, 0);
    req(0, 2'd1, 1, 32'h100, 16'h0002, 0);
    req(0, 2'd1, 0, 32'h108, 16'h0000, 0);
    req(0, 2'd1, 1, 32'h108, 16'h0002, 0);
    req(0, 2'd1, 0, 32'h10A, 16'h0000, 0);
    // R8 word loads, R1 negative displacement
    req(0, 2'd2, 0, 32'h108, 16'hFFF8, 0);
    req(0, 2'd2, 1, 32'h104, 16'h0000, 0);
    // R5 misaligned requests
    req(1, 2'd1, 0, 32'h101, 16'h0000, 32'hFFFFFFFF);
    req(1, 2'd2, 0, 32'h100, 16'h0002, 32'hFFFFFFFF);
    req(1, 2'd3, 0, 32'h104, 16'h0000, 32'hFFFFFFFF);
    req(0, 2'd1, 0, 32'h103, 16'h0000, 0);
    req(0, 2'd2, 0, 32'h101, 16'h0000, 0);
    req(0, 2'd3, 1, 32'h100, 16'h0000, 0);
    idle();
    // R5 memory untouched after rejected stores
    req(0, 2'd2, 0, 32'h100, 16'h0000, 0);
    req(0, 2'd2, 0, 32'h104, 16'h0000, 0);
    // R10 store immediately followed by load of same word
    req(1, 2'd0, 0, 32'h110, 16'h0003, 32'h000000F0);
    req(0, 2'd0, 0, 32'h113, 16'h0000, 0);
    req(0, 2'd2, 0, 32'h110, 16'h0000, 0);
    idle(); idle(); idle();
    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule